// File: doc/BRIEF.md
# Multiplier-Based Dynamic Barrel Shifter

This block shifts or rotates a 32-bit word in a single pass through a multiplier. The shift distance N is not given as a count. The caller supplies it as a one-hot multiplicand equal to 2^N. The data word is multiplied by that value, and the 64-bit product is cut into a lower and an upper word. The lower word is the data shifted left by N. The upper word is the data shifted right by 32-N. The OR of the two words is a left rotation by N.

Each cycle a fresh operation may be chosen from four controls: a rotate flag, a direction flag, and one signedness flag for each operand. When the data operand is signed, the multiplier sees the data sign-extended, so a right shift fills from the sign bit. The result is registered one cycle after the request, and a result-valid flag follows the request-valid flag. A distance operand that is not one-hot is a caller error and gives an undefined result.

Top module: `mulshift_unit`

## Requirements
- R1: While reset is high and in the cycle after it, `out_vld` is 0 and `out_res` is 0.
- R2: A request taken on a rising edge with `in_vld`=1 appears on `out_res` after that same edge, and `out_vld` equals the value `in_vld` had before that edge.
- R3: When `in_vld` is 0, `out_res` keeps its previous value.
- R4: With `in_rot`=0, `in_right`=0 and `in_sgn_data`=0, the result is the data shifted left by N with zero fill. Example: 0xAABBCCDD with distance 0x00000100 gives 0xBBCCDD00.
- R5: With `in_rot`=0, `in_right`=0, `in_sgn_data`=1 and `in_sgn_dist`=0 (arithmetic left), the result equals the logical left shift by N.
- R6: With `in_rot`=0, `in_right`=1 and logical signedness, the result is the data shifted right by 32-N with zero fill, for N from 1 to 31.
- R7: With `in_rot`=0, `in_right`=1, `in_sgn_data`=1 and `in_sgn_dist`=0 (arithmetic right), the result is the data shifted right by 32-N with copies of data bit 31 filled in. Example: 0xAABBCCDD with distance 0x00000100 gives 0xFFFFFFAA.
- R8: With `in_rot`=1, the result is the data rotated left by N, whatever the values of `in_right` and both signedness flags. Example: 0xAABBCCDD with distance 0x00000100 gives 0xBBCCDDAA.
- R9: A distance operand of 0x00000001 returns the data unchanged in every mode.
- R10: With `in_sgn_dist`=1, the shift is logical whatever the value of `in_sgn_data`. A right shift then fills with zeros.
- R11: The mode may change on every request. Back-to-back requests in different modes each return their own correct result in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Request valid |
| in_data | input | 32 | Data word to shift or rotate |
| in_dist | input | 32 | Distance as a one-hot value 2^N |
| in_rot | input | 1 | 1 selects rotate |
| in_right | input | 1 | 1 selects a right shift when not rotating |
| in_sgn_data | input | 1 | Data operand is signed |
| in_sgn_dist | input | 1 | Distance operand is signed (forces a logical shift) |
| out_vld | output | 1 | Result valid |
| out_res | output | 32 | Registered result |

## Verification
A mode switch and a pipeline update can land in the same cycle. While the result of one request is being registered, the next request in a different mode is already presented. The bench provokes this by issuing an arithmetic right shift, then a rotate, then a logical left shift on consecutive edges, with no idle cycle between them. Each registered word is compared in its own cycle against a reference built from shift operators, so a result that leaks from the previous mode or lands late is caught.

// File: rtl/mulshift_pkg.sv
package mulshift_pkg;

    typedef enum logic [2:0] {
        OP_LSL = 3'd0,
        OP_ASL = 3'd1,
        OP_LSR = 3'd2,
        OP_ASR = 3'd3,
        OP_ROT = 3'd4
    } shop_e;

    typedef struct packed {
        logic rot;
        logic right;
        logic sgn_data;
        logic sgn_dist;
    } shctl_t;

    typedef struct packed {
        shop_e op;
        logic  ext_sign;
        logic  take_lo;
        logic  take_hi;
    } shplan_t;

    function automatic shop_e decode_op(input shctl_t c);
        logic arith;
        arith = c.sgn_data & ~c.sgn_dist;
        if (c.rot)        return OP_ROT;
        else if (c.right) return arith ? OP_ASR : OP_LSR;
        else              return arith ? OP_ASL : OP_LSL;
    endfunction

    function automatic logic op_signed(input shop_e op);
        return (op == OP_ASR) || (op == OP_ASL);
    endfunction

endpackage

// File: rtl/mulshift_decode.sv
module mulshift_decode
    import mulshift_pkg::*;
(
    input  shctl_t  ctl,
    output shplan_t plan
);
    shop_e op;

    always_comb begin
        op            = decode_op(ctl);
        plan.op       = op;
        plan.ext_sign = op_signed(op);
        plan.take_lo  = (op == OP_LSL) || (op == OP_ASL) || (op == OP_ROT);
        plan.take_hi  = (op == OP_LSR) || (op == OP_ASR) || (op == OP_ROT);
    end
endmodule

// File: rtl/mulshift_mult.sv
module mulshift_mult #(
    parameter int DW = 32
) (
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic            a_signed,
    output logic [2*DW-1:0] prod
);
    localparam int PW = 2 * DW;

    logic [PW-1:0] a_w;
    logic [PW-1:0] b_w;

    // Truncated PW-bit product is identical for signed and unsigned
    // operands once they are extended to PW bits.
    always_comb begin
        a_w  = {{DW{a_signed & a[DW-1]}}, a};
        b_w  = {{DW{1'b0}}, b};
        prod = a_w * b_w;
    end
endmodule

// File: rtl/mulshift_select.sv
module mulshift_select
    import mulshift_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [2*DW-1:0] prod,
    input  logic [DW-1:0]   data,
    input  logic            unit_dist,
    input  shplan_t         plan,
    output logic [DW-1:0]   res
);
    localparam int PW = 2 * DW;

    logic [DW-1:0] lo_w;
    logic [DW-1:0] hi_w;

    always_comb begin
        lo_w = prod[DW-1:0];
        hi_w = prod[PW-1:DW];
        res  = '0;
        if (plan.take_lo) res = res | lo_w;
        if (plan.take_hi) res = res | hi_w;
        // 2^0 would mean a right shift by the full width; pass data through.
        if (unit_dist)    res = data;
    end
endmodule

// File: rtl/mulshift_unit.sv
module mulshift_unit
    import mulshift_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_vld,
    input  logic [DW-1:0] in_data,
    input  logic [DW-1:0] in_dist,
    input  logic          in_rot,
    input  logic          in_right,
    input  logic          in_sgn_data,
    input  logic          in_sgn_dist,
    output logic          out_vld,
    output logic [DW-1:0] out_res
);
    localparam int PW = 2 * DW;

    shctl_t        ctl;
    shplan_t       plan;
    logic [PW-1:0] prod;
    logic [DW-1:0] nxt_res;
    logic          unit_dist;

    assign ctl       = '{rot: in_rot, right: in_right,
                         sgn_data: in_sgn_data, sgn_dist: in_sgn_dist};
    assign unit_dist = (in_dist == DW'(1));

    mulshift_decode u_dec (
        .ctl  (ctl),
        .plan (plan)
    );

    mulshift_mult #(.DW(DW)) u_mul (
        .a        (in_data),
        .b        (in_dist),
        .a_signed (plan.ext_sign),
        .prod     (prod)
    );

    mulshift_select #(.DW(DW)) u_sel (
        .prod      (prod),
        .data      (in_data),
        .unit_dist (unit_dist),
        .plan      (plan),
        .res       (nxt_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            out_res <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) out_res <= nxt_res;
        end
    end
endmodule

// File: rtl/mulshift_chk.sv
module mulshift_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          in_vld,
    input logic [DW-1:0] in_data,
    input logic [DW-1:0] in_dist,
    input logic          in_rot,
    input logic          in_right,
    input logic          in_sgn_data,
    input logic          in_sgn_dist,
    input logic          out_vld,
    input logic [DW-1:0] out_res
);
    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_vld && out_res == '0));

    // R2
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);

    // R3
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> ($stable(out_res) && !out_vld));

    // R8
    a_r8_rotate_keeps_ones: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_rot && $onehot(in_dist))
        |=> ($countones(out_res) == $countones($past(in_data))));

    // R9
    a_r9_unit_passthru: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_dist == DW'(1)) |=> (out_res == $past(in_data)));

    // R6 / R10: logical right with N>=1 zero-fills the top bit
    a_r6_lsr_zero_top: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !in_rot && in_right && (!in_sgn_data || in_sgn_dist)
         && $onehot(in_dist) && in_dist != DW'(1))
        |=> (out_res[DW-1] == 1'b0));

    // R7
    a_r7_asr_sign_top: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !in_rot && in_right && in_sgn_data && !in_sgn_dist
         && $onehot(in_dist))
        |=> (out_res[DW-1] == $past(in_data[DW-1])));
endmodule

bind mulshift_unit mulshift_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_vld      (in_vld),
    .in_data     (in_data),
    .in_dist     (in_dist),
    .in_rot      (in_rot),
    .in_right    (in_right),
    .in_sgn_data (in_sgn_data),
    .in_sgn_dist (in_sgn_dist),
    .out_vld     (out_vld),
    .out_res     (out_res)
);

// File: tb/sim_mulshift_unit.sv
module sim_mulshift_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [31:0] in_data = '0;
    logic [31:0] in_dist = 32'd1;
    logic        in_rot = 1'b0;
    logic        in_right = 1'b0;
    logic        in_sgn_data = 1'b0;
    logic        in_sgn_dist = 1'b0;
    logic        out_vld;
    logic [31:0] out_res;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mulshift_unit u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data),
        .in_dist(in_dist), .in_rot(in_rot), .in_right(in_right),
        .in_sgn_data(in_sgn_data), .in_sgn_dist(in_sgn_dist),
        .out_vld(out_vld), .out_res(out_res)
    );

    function automatic logic [31:0] model(input logic [31:0] d, input int n,
        input logic rot, input logic right, input logic sa, input logic sb);
        if (n == 0) return d;
        if (rot) return (d << n) | (d >> (32 - n));
        if (!right) return d << n;
        if (sa && !sb) return 32'($signed(d) >>> (32 - n));
        return d >> (32 - n);
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic present(input logic [31:0] d, input int n, input logic rot,
        input logic right, input logic sa, input logic sb);
        in_vld = 1'b1; in_data = d; in_dist = 32'd1 << n;
        in_rot = rot; in_right = right; in_sgn_data = sa; in_sgn_dist = sb;
    endtask

    task automatic run_one(input string req, input logic [31:0] d, input int n,
        input logic rot, input logic right, input logic sa, input logic sb);
        @(negedge clk);
        present(d, n, rot, right, sa, sb);
        @(negedge clk);
        in_vld = 1'b0;
        check(req, out_res, model(d, n, rot, right, sa, sb));
        check({req, " valid"}, {31'd0, out_vld}, 32'd1);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 vld", {31'd0, out_vld}, 32'd0);
        check("R1 res", out_res, 32'd0);
    endtask

    task automatic t_left;
        run_one("R4 example", 32'hAABBCCDD, 8, 0, 0, 0, 0);
        check("R4 literal", out_res, 32'hBBCCDD00);
        for (int n = 1; n < 32; n += 5) run_one("R4 sweep", 32'h8765_4321, n, 0, 0, 0, 0);
        run_one("R5 asl", 32'hAABBCCDD, 8, 0, 0, 1, 0);
        check("R5 literal", out_res, 32'hBBCCDD00);
        run_one("R5 asl n31", 32'h0000_0003, 31, 0, 0, 1, 0);
    endtask

    task automatic t_right;
        for (int n = 1; n < 32; n += 6) run_one("R6 lsr", 32'hF0F0_1234, n, 0, 1, 0, 0);
        run_one("R6 lsr n31", 32'h8000_0001, 31, 0, 1, 0, 0);
        run_one("R7 example", 32'hAABBCCDD, 8, 0, 1, 1, 0);
        check("R7 literal", out_res, 32'hFFFFFFAA);
        run_one("R7 positive", 32'h7ABB_CCDD, 4, 0, 1, 1, 0);
        run_one("R7 n31", 32'h8000_0010, 31, 0, 1, 1, 0);
    endtask

    task automatic t_rotate;
        run_one("R8 example", 32'hAABBCCDD, 8, 1, 0, 0, 0);
        check("R8 literal", out_res, 32'hBBCCDDAA);
        run_one("R8 right+signed ignored", 32'hAABBCCDD, 8, 1, 1, 1, 0);
        check("R8 literal2", out_res, 32'hBBCCDDAA);
        run_one("R8 n31", 32'h8000_0001, 31, 1, 0, 1, 1);
    endtask

    task automatic t_unit;
        run_one("R9 lsl", 32'hDEAD_BEEF, 0, 0, 0, 0, 0);
        run_one("R9 lsr", 32'hDEAD_BEEF, 0, 0, 1, 0, 0);
        run_one("R9 asr", 32'hDEAD_BEEF, 0, 0, 1, 1, 0);
        check("R9 literal", out_res, 32'hDEAD_BEEF);
        run_one("R9 rot", 32'hDEAD_BEEF, 0, 1, 0, 0, 0);
    endtask

    task automatic t_sgn_dist;
        run_one("R10 right", 32'hAABBCCDD, 8, 0, 1, 1, 1);
        check("R10 literal", out_res, 32'h000000AA);
        run_one("R10 left", 32'hAABBCCDD, 8, 0, 0, 1, 1);
    endtask

    task automatic t_hold;
        run_one("R3 setup", 32'h1234_5678, 4, 0, 0, 0, 0);
        @(negedge clk);
        in_data = 32'hFFFF_FFFF; in_dist = 32'd2; in_rot = 1'b1;
        @(negedge clk);
        check("R3 hold", out_res, 32'h2345_6780);
        check("R2 vld low", {31'd0, out_vld}, 32'd0);
    endtask

    task automatic t_b2b;
        @(negedge clk);
        present(32'hAABBCCDD, 8, 0, 1, 1, 0);
        @(negedge clk);
        check("R11 asr", out_res, 32'hFFFFFFAA);
        present(32'hAABBCCDD, 8, 1, 0, 0, 0);
        @(negedge clk);
        check("R11 rot", out_res, 32'hBBCCDDAA);
        present(32'h0000_00F1, 4, 0, 0, 0, 0);
        @(negedge clk);
        check("R11 lsl", out_res, 32'h0000_0F10);
        check("R2 vld", {31'd0, out_vld}, 32'd1);
        in_vld = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        check("R1 after", {31'd0, out_vld}, 32'd0);
        t_left();
        t_right();
        t_rotate();
        t_unit();
        t_sgn_dist();
        t_hold();
        t_b2b();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule